// File: doc/BRIEF.md
# Freeze-Mode Power Controller

This controller moves a block of core logic between normal operation and a retention state in which nothing toggles but every register and memory keeps its value. A request comes in on an active-low pin. The pin is synchronised and filtered. The controller then removes the core's clock enables and freezes the values that the core sees on its inputs. It also turns every output pad into either a floating driver or a weak pull, chosen per output. When the request is withdrawn, the clock enables come back and the core carries on with its stored data unchanged.

There are two entry modes. In direct mode the controller freezes as soon as it accepts a request. In approved mode it waits for a safe-to-freeze signal from user logic, which sees the synchronised pin on its own output. A global enable turns the freeze function off. The pin is then only an ordinary synchronised input.

Top module: `frz_power_ctrl`

## Requirements
- R1: After reset the controller is in the active state: `frozen_o` and `in_hold_o` are 0, `ce_o` equals `ce_req_i`, `core_in_o` equals `ext_in_i`, and the pads follow `core_out_i`/`core_oe_i` with both pull outputs at 0.
- R2: `pin_sync_o` equals the value of `frz_pin_n` that was sampled two rising edges earlier. It resets to 1.
- R3: A freeze request is accepted only when two successive synchronised samples of the pin are both 0. A low pulse that lasts one clock is ignored. With direct entry, the pin going low before rising edge k makes `frozen_o` read 1 after edge k+3.
- R4: When `safe_hs_en` = 0, an accepted request moves the controller straight to the frozen state.
- R5: When `safe_hs_en` = 1, an accepted request waits with the core still running until `user_safe` is 1. If the request is withdrawn (two successive high samples) before that happens, the controller goes back to active without freezing.
- R6: While gating is in force, every bit of `ce_o` is 0 whatever `ce_req_i` is. Gating covers the frozen state and the one cycle after it. `frozen_o` and `in_hold_o` are 1 exactly while gating is in force.
- R7: While gating is in force, `core_in_o` holds the value of `ext_in_i` captured at the edge that started gating. Changes on `ext_in_i` have no effect until gating ends. After that, `core_in_o` follows `ext_in_i` again.
- R8: While gating is in force, `pad_oe_o` = 0, `pad_out_o` = 0, `pad_pull_en_o` = `pull_en_cfg` and `pad_pull_up_o` = `pull_up_cfg`. A bit with pull_en 1 and pull_up 1 pulls up, pull_en 1 and pull_up 0 pulls down, and pull_en 0 floats. When gating is not in force, both pull outputs are 0.
- R9: While `freeze_used` = 0, pin activity never starts gating, and any pending or frozen state is released.
- R10: Exit also needs two successive high samples. After the frozen state there is one waking cycle, and the controller is then active with the core's inputs and pads live again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frz_pin_n | input | 1 | Asynchronous freeze request pin, low = request |
| freeze_used | input | 1 | 1 enables the freeze function |
| safe_hs_en | input | 1 | 1 selects approved entry |
| user_safe | input | 1 | User logic approves entry |
| pin_sync_o | output | 1 | Synchronised pin value for user logic |
| ce_req_i | input | NUM_CE | Clock enables wanted by the core |
| ce_o | output | NUM_CE | Gated clock enables |
| ext_in_i | input | NUM_IN | Inputs arriving from pads |
| core_in_o | output | NUM_IN | Inputs presented to the core |
| in_hold_o | output | 1 | Input hold in force |
| core_out_i | input | NUM_OUT | Output data from the core |
| core_oe_i | input | NUM_OUT | Output enables from the core |
| pull_en_cfg | input | NUM_OUT | Per-output weak pull enable used in freeze |
| pull_up_cfg | input | NUM_OUT | Per-output pull direction, 1 = up |
| pad_out_o | output | NUM_OUT | Pad data |
| pad_oe_o | output | NUM_OUT | Pad driver enable |
| pad_pull_en_o | output | NUM_OUT | Pad weak pull enable |
| pad_pull_up_o | output | NUM_OUT | Pad pull direction |
| frozen_o | output | 1 | Status: clock enables gated |

## Verification
A pin change shows on `pin_sync_o` two edges later. It shows as gating three edges later in direct mode, because the acceptance needs a third register. A safe approval adds one edge, because it is taken in the waiting state. Leaving the frozen state needs the same three edges plus the waking cycle. Gated enables, held inputs and pad controls are combinational from the state, so they change in the same cycle as `frozen_o`. The bench keeps a behavioural model that it updates on each rising edge from inputs that are steady at that edge. The bench compares every output half a cycle later. Directed checks wait a fixed number of edges worked out from the counts above.

// File: rtl/frz_pkg.sv
package frz_pkg;

  typedef enum logic [1:0] {
    FZ_ACTIVE = 2'd0,
    FZ_WAIT   = 2'd1,
    FZ_FROZEN = 2'd2,
    FZ_WAKE   = 2'd3
  } fz_state_e;

  // gating applies in the frozen state and the single waking cycle after it
  function automatic logic fz_gating(input fz_state_e st);
    return (st == FZ_FROZEN) || (st == FZ_WAKE);
  endfunction

  function automatic fz_state_e fz_next(input fz_state_e st,
                                        input logic req,
                                        input logic rel,
                                        input logic hs_en,
                                        input logic safe);
    fz_state_e nx;
    nx = st;
    unique case (st)
      FZ_ACTIVE: if (req) nx = hs_en ? FZ_WAIT : FZ_FROZEN;
      FZ_WAIT: begin
        if (rel)       nx = FZ_ACTIVE;
        else if (safe) nx = FZ_FROZEN;
      end
      FZ_FROZEN: if (rel) nx = FZ_WAKE;
      FZ_WAKE:   nx = FZ_ACTIVE;
      default:   nx = FZ_ACTIVE;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/frz_pin_filter.sv
module frz_pin_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic used,
  output logic pin_sync,
  output logic req,
  output logic rel
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[DEPTH-2:0], pin_n};
  end

  // synchronised sample and the one before it
  logic cur_s, prev_s;
  assign cur_s    = chain_q[SYNC_STAGES-1];
  assign prev_s   = chain_q[SYNC_STAGES];
  assign pin_sync = cur_s;

  assign req = used & ~cur_s & ~prev_s;
  assign rel = ~used | (cur_s & prev_s);

  // R3
  req_rel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && rel));

endmodule

// File: rtl/frz_fsm.sv
module frz_fsm
  import frz_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  logic      rel,
  input  logic      hs_en,
  input  logic      safe,
  output fz_state_e state,
  output logic      gate
);
  fz_state_e state_q, state_d;

  assign state_d = fz_next(state_q, req, rel, hs_en, safe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FZ_ACTIVE;
    else        state_q <= state_d;
  end

  assign state = state_q;
  assign gate  = fz_gating(state_q);

  // R10
  wake_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FZ_WAKE) |=> (state_q == FZ_ACTIVE));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FZ_WAIT && !safe && !rel) |=> (state_q == FZ_WAIT));

  // R4
  direct_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FZ_ACTIVE && req && !hs_en) |=> (state_q == FZ_FROZEN));

  // R9
  unused_no_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FZ_ACTIVE && !req) |=> (state_q == FZ_ACTIVE));

endmodule

// File: rtl/frz_io_hold.sv
module frz_io_hold #(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gate,
  input  logic [NUM_IN-1:0]  ext_in,
  output logic [NUM_IN-1:0]  core_in,
  input  logic [NUM_OUT-1:0] core_out,
  input  logic [NUM_OUT-1:0] core_oe,
  input  logic [NUM_OUT-1:0] pull_en,
  input  logic [NUM_OUT-1:0] pull_up,
  output logic [NUM_OUT-1:0] pad_out,
  output logic [NUM_OUT-1:0] pad_oe,
  output logic [NUM_OUT-1:0] pad_pull_en,
  output logic [NUM_OUT-1:0] pad_pull_up
);
  logic [NUM_IN-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held_q <= '0;
    else if (!gate) held_q <= ext_in;
  end

  assign core_in = gate ? held_q : ext_in;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pad
    always_comb begin
      if (gate) begin
        pad_out[i]     = 1'b0;
        pad_oe[i]      = 1'b0;
        pad_pull_en[i] = pull_en[i];
        pad_pull_up[i] = pull_up[i];
      end else begin
        pad_out[i]     = core_out[i];
        pad_oe[i]      = core_oe[i];
        pad_pull_en[i] = 1'b0;
        pad_pull_up[i] = 1'b0;
      end
    end
  end

  // R7
  in_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && $past(gate)) |-> $stable(core_in));

  // R8
  pad_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (pad_oe == '0));

endmodule

// File: rtl/frz_power_ctrl.sv
module frz_power_ctrl
  import frz_pkg::*;
#(
  parameter int NUM_CE  = 4,
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frz_pin_n,
  input  logic               freeze_used,
  input  logic               safe_hs_en,
  input  logic               user_safe,
  output logic               pin_sync_o,
  input  logic [NUM_CE-1:0]  ce_req_i,
  output logic [NUM_CE-1:0]  ce_o,
  input  logic [NUM_IN-1:0]  ext_in_i,
  output logic [NUM_IN-1:0]  core_in_o,
  output logic               in_hold_o,
  input  logic [NUM_OUT-1:0] core_out_i,
  input  logic [NUM_OUT-1:0] core_oe_i,
  input  logic [NUM_OUT-1:0] pull_en_cfg,
  input  logic [NUM_OUT-1:0] pull_up_cfg,
  output logic [NUM_OUT-1:0] pad_out_o,
  output logic [NUM_OUT-1:0] pad_oe_o,
  output logic [NUM_OUT-1:0] pad_pull_en_o,
  output logic [NUM_OUT-1:0] pad_pull_up_o,
  output logic               frozen_o
);
  logic      req_ev, rel_ev, gate;
  fz_state_e state;

  frz_pin_filter #(.SYNC_STAGES(2)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_n    (frz_pin_n),
    .used     (freeze_used),
    .pin_sync (pin_sync_o),
    .req      (req_ev),
    .rel      (rel_ev)
  );

  frz_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_ev),
    .rel   (rel_ev),
    .hs_en (safe_hs_en),
    .safe  (user_safe),
    .state (state),
    .gate  (gate)
  );

  frz_io_hold #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_io (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate        (gate),
    .ext_in      (ext_in_i),
    .core_in     (core_in_o),
    .core_out    (core_out_i),
    .core_oe     (core_oe_i),
    .pull_en     (pull_en_cfg),
    .pull_up     (pull_up_cfg),
    .pad_out     (pad_out_o),
    .pad_oe      (pad_oe_o),
    .pad_pull_en (pad_pull_en_o),
    .pad_pull_up (pad_pull_up_o)
  );

  for (genvar c = 0; c < NUM_CE; c++) begin : g_ce
    assign ce_o[c] = ce_req_i[c] & ~gate;
  end

  assign frozen_o  = gate;
  assign in_hold_o = gate;

  // R6
  ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_o |-> (ce_o == '0));

  // R6
  ce_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen_o) |-> (ce_o == ce_req_i));

  // R8
  pull_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen_o) |-> (pad_pull_en_o == '0));

endmodule

// File: tb/frz_power_ctrl_tb.sv
module frz_power_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCE = 4, NIN = 8, NOUT = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frz_pin_n = 1'b1, freeze_used = 1'b1, safe_hs_en = 1'b0, user_safe = 1'b0;
  logic pin_sync_o, in_hold_o, frozen_o;
  logic [NCE-1:0]  ce_req_i = '1, ce_o;
  logic [NIN-1:0]  ext_in_i = 8'hA5, core_in_o;
  logic [NOUT-1:0] core_out_i = 8'h3C, core_oe_i = 8'hFF;
  logic [NOUT-1:0] pull_en_cfg = 8'h0F, pull_up_cfg = 8'h05;
  logic [NOUT-1:0] pad_out_o, pad_oe_o, pad_pull_en_o, pad_pull_up_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  frz_power_ctrl #(.NUM_CE(NCE), .NUM_IN(NIN), .NUM_OUT(NOUT)) dut_i (.*);

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 active, 1 waiting, 2 frozen, 3 waking
  int   mst = 0;
  bit   pins[$] = '{1, 1, 1};
  logic [NIN-1:0] m_held = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; pins = '{1, 1, 1}; m_held = '0;
    end else begin
      bit lo2, hi2, g;
      lo2 = freeze_used && !pins[1] && !pins[2];
      hi2 = !freeze_used || (pins[1] && pins[2]);
      g = (mst >= 2);
      if (!g) m_held = ext_in_i;
      case (mst)
        0: if (lo2) mst = safe_hs_en ? 1 : 2;
        1: if (hi2) mst = 0; else if (user_safe) mst = 2;
        2: if (hi2) mst = 3;
        default: mst = 0;
      endcase
      pins.push_front(frz_pin_n);
      void'(pins.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit g;
      g = (mst >= 2);
      chk("R2 pin_sync", pin_sync_o, pins[1]);
      chk("R6 frozen", frozen_o, g);
      chk("R6 in_hold", in_hold_o, g);
      chk("R6 ce", ce_o, g ? '0 : ce_req_i);
      chk("R7 core_in", core_in_o, g ? m_held : ext_in_i);
      chk("R8 pad_oe", pad_oe_o, g ? '0 : core_oe_i);
      chk("R8 pad_out", pad_out_o, g ? '0 : core_out_i);
      chk("R8 pull_en", pad_pull_en_o, g ? pull_en_cfg : '0);
      chk("R8 pull_up", pad_pull_up_o, g ? pull_up_cfg : '0);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R1 reset state
    chk("R1 frozen", frozen_o, 0);
    chk("R1 ce", ce_o, 4'hF);
    chk("R1 pad_oe", pad_oe_o, 8'hFF);
    chk("R1 pull_en", pad_pull_en_o, 0);

    // R3 single-cycle low pulse ignored
    frz_pin_n = 0; wait_cyc(1); frz_pin_n = 1;
    wait_cyc(6);
    chk("R3 glitch ignored", frozen_o, 0);

    // R4 direct entry, frozen after edge k+3
    frz_pin_n = 0;
    wait_cyc(3);
    chk("R3 not yet frozen", frozen_o, 0);
    wait_cyc(1);
    chk("R4 frozen", frozen_o, 1);
    for (int i = 0; i < 5; i++) begin
      ext_in_i = 8'h10 + i[7:0]; ce_req_i = i[3:0]; wait_cyc(1);
      chk("R7 input held", core_in_o, 8'hA5);
      chk("R6 ce gated", ce_o, 0);
    end
    chk("R8 pull_en", pad_pull_en_o, 8'h0F);
    pull_en_cfg = 8'hF0; pull_up_cfg = 8'hA0; wait_cyc(1);
    chk("R8 pull_up", pad_pull_up_o, 8'hA0);

    // R10 exit: gating through waking cycle, then active
    frz_pin_n = 1; ce_req_i = 4'hF;
    wait_cyc(4);
    chk("R10 waking still gated", frozen_o, 1);
    wait_cyc(1);
    chk("R10 active again", frozen_o, 0);
    chk("R10 ce live", ce_o, 4'hF);
    chk("R7 input live", core_in_o, ext_in_i);

    // R5 approved entry, withdrawn request
    safe_hs_en = 1; frz_pin_n = 0;
    wait_cyc(8);
    chk("R5 waiting, not frozen", frozen_o, 0);
    frz_pin_n = 1; wait_cyc(6);
    user_safe = 1; wait_cyc(3);
    chk("R5 withdrawn, not frozen", frozen_o, 0);
    user_safe = 0;
    frz_pin_n = 0; wait_cyc(8);
    chk("R5 still waiting", frozen_o, 0);
    user_safe = 1; wait_cyc(2);
    chk("R5 approved entry", frozen_o, 1);
    user_safe = 0; frz_pin_n = 1; wait_cyc(8);
    chk("R10 exit after approved", frozen_o, 0);

    // R9 freeze unused: pin is an ordinary input
    safe_hs_en = 0; freeze_used = 0;
    frz_pin_n = 0; wait_cyc(10);
    chk("R9 no freeze", frozen_o, 0);
    chk("R2 pin seen", pin_sync_o, 0);
    freeze_used = 1; wait_cyc(5);
    chk("R9 re-enabled freezes", frozen_o, 1);
    freeze_used = 0; wait_cyc(1);
    chk("R9 disable releases (waking)", frozen_o, 1);
    wait_cyc(1);
    chk("R9 released", frozen_o, 0);
    frz_pin_n = 1; freeze_used = 1;
    wait_cyc(5);
    finish_run();
  end
endmodule